// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block watches a key matrix wired as six drive lines crossing five sense lines. While nothing is pressed it parks the drive lines at an idle pattern and waits. The first active sense line starts a scan window: each drive line is raised alone for a fixed slot while the sense lines are sampled, and the whole matrix is read twice. Only when both reads give the same image is that image accepted. A non-empty accepted image is published as a 30-bit key word together with a flag saying whether the part was asleep when the press began, and an active-low read request is asserted for the host.

All timing is counted in ticks of an oscillator clock enable (`osc_tick`) on the system clock. One pass over the matrix takes `SCAN_LEN` ticks, and a decision is taken `ACCEPT_LEN` ticks after the window opens. If the two passes disagree, the window restarts, so a press that bounces once is reported after twice the budget. After the host signals that it has read the data, the request is withdrawn and a fresh window begins. Scanning continues in this way until an accepted image is empty, which means every key has been released. In sleep the idle drive pattern follows a 2-bit code, and a press seen on a raised line requests that the oscillator be woken.

The sequencer has five states. `KS_IDLE` goes to `KS_SCAN_A` on a tick with any sense line active. `KS_SCAN_A` goes to `KS_SCAN_B`, and `KS_SCAN_B` goes to `KS_SETTLE`, each at the end of a pass. `KS_SETTLE` leaves on the last tick of the window. It goes back to `KS_SCAN_A` if the images differ, to `KS_IDLE` if they agree and are empty, and to `KS_REQ` if they agree and are non-empty. `KS_REQ` goes to `KS_SCAN_A` on `read_done`.

Top module: `key_matrix_scanner`

## Requirements
- R1: A key on drive line r (1 to 6) and sense line c (1 to 5) is reported in `key_data` bit 5*(r-1)+(c-1), with bit 0 as the least significant bit.
- R2: When both passes of a window agree on a non-empty image, `req_n` goes low exactly `ACCEPT_LEN` (800) ticks after the clock edge that opened the window. `key_data` and `sleep_ack` take their new values at that same edge and change at no other time.
- R3: When the two passes disagree, `key_data` is kept and the window restarts, so a press that settles during the first window is reported after 1600 ticks. A press shorter than the window is never reported.
- R4: In normal mode (`sleep_code` = 00) all six drive lines idle high. During a pass, each drive line in turn is the only one high, for one slot of `SCAN_LEN`/6 = 62 ticks, in the order line 1 to line 6.
- R5: Several held keys are reported as several set bits. When an agreed image is empty, `key_data` becomes zero and the block returns to idle without raising a request.
- R6: A `read_done` pulse while the request is active makes `req_n` high on the next clock and opens a new window. If keys are still held, the request returns 800 ticks later. A `read_done` pulse at any other time is ignored.
- R7: While `xfer_active` is high, `req_n` is high in the same cycle. A pending request returns as soon as `xfer_active` falls.
- R8: With `row_sel` = 00 all six lines are key rows. With 01, line 1 is removed. With 1x, lines 1 and 2 are removed. A removed line is never driven high, and its `key_data` bits read 0.
- R9: When the scanner is idle, `sleep_code` 01 drives only line 6 high, 10 drives lines 5 and 6 high, and 11 drives all six high.
- R10: `sleep_ack` is 1 when the reported press began while `sleep_code` was non-zero, and 0 otherwise.
- R11: In sleep, with the scanner idle and no sense line active, `osc_wake` is 0. A press on a raised line sets `osc_wake` to 1 in the same cycle. Outside sleep, `osc_wake` is 1.
- R12: While `rst_n` is low, `key_data` and `sleep_ack` are 0, `req_n` is high, no scan starts, and only drive line 6 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator clock enable, one tick per oscillator period |
| sense | input | 5 | Matrix sense lines, high when a key on a raised drive line is pressed |
| sleep_code | input | 2 | 00 normal, other values select the sleep idle pattern |
| row_sel | input | 2 | Number of low drive lines given away to other use |
| xfer_active | input | 1 | Host serial transfer in progress |
| read_done | input | 1 | One-cycle pulse: host has read the key data |
| drive | output | 6 | Matrix drive lines, bit 0 is line 1 |
| key_data | output | 30 | Accepted key image |
| sleep_ack | output | 1 | Press began while asleep |
| req_n | output | 1 | Active-low read request |
| osc_wake | output | 1 | Request to run the oscillator |

## Verification
The hardest case to reach is a window whose two passes disagree, because a key has to change between the two samples of the same line. The bench holds one key from the start. It adds a second key on line 5 after 400 ticks, which falls after line 5 was sampled in the first pass and before it is sampled in the second. The bench then expects the request only at 1600 ticks. A press released after 300 ticks exercises the same mismatch path ending in an empty image, and the bench checks that no request appears.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
    typedef enum logic [2:0] {
        KS_IDLE,
        KS_SCAN_A,
        KS_SCAN_B,
        KS_SETTLE,
        KS_REQ
    } kscan_state_e;
endpackage

// File: rtl/kscan_fsm.sv
module kscan_fsm
    import kscan_pkg::*;
#(
    parameter int NUM_DRV    = 6,
    parameter int SCAN_LEN   = 375,
    parameter int ACCEPT_LEN = 800,
    localparam int SLOT_LEN  = SCAN_LEN / NUM_DRV,
    localparam int ROW_W     = $clog2(NUM_DRV + 1),
    localparam int SLOT_W    = $clog2(SLOT_LEN),
    localparam int PASS_W    = $clog2(SCAN_LEN),
    localparam int WIN_W     = $clog2(ACCEPT_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sense_any,
    input  logic             read_done,
    input  logic             match,
    input  logic             image_zero,
    output kscan_state_e     state_o,
    output logic [ROW_W-1:0] row_o,
    output logic             sample_o,
    output logic             sample_b_o,
    output logic             start_o,
    output logic             eval_o
);
    kscan_state_e      state_q, state_d;
    logic [WIN_W-1:0]  win_q;
    logic [PASS_W-1:0] pass_q;
    logic [SLOT_W-1:0] slot_q;
    logic [ROW_W-1:0]  row_q;
    logic              scanning, pass_end, restart;

    assign scanning = (state_q == KS_SCAN_A) || (state_q == KS_SCAN_B);
    assign pass_end = tick && scanning && (pass_q == PASS_W'(SCAN_LEN - 1));
    assign restart  = start_o || (eval_o && !match);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_IDLE:   if (tick && sense_any) state_d = KS_SCAN_A;
            KS_SCAN_A: if (pass_end) state_d = KS_SCAN_B;
            KS_SCAN_B: if (pass_end) state_d = KS_SETTLE;
            KS_SETTLE: if (eval_o) state_d = !match ? KS_SCAN_A :
                                             (image_zero ? KS_IDLE : KS_REQ);
            KS_REQ:    if (read_done) state_d = KS_SCAN_A;
            default:   state_d = KS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_d;
    end

    // window, pass, slot and row counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            pass_q <= '0;
            slot_q <= '0;
            row_q  <= '0;
        end else if (restart) begin
            win_q  <= '0;
            pass_q <= '0;
            slot_q <= '0;
            row_q  <= '0;
        end else if (tick && (scanning || state_q == KS_SETTLE)) begin
            win_q <= win_q + 1'b1;
            if (pass_end) begin
                pass_q <= '0;
                slot_q <= '0;
                row_q  <= '0;
            end else if (scanning) begin
                pass_q <= pass_q + 1'b1;
                if (sample_o) begin
                    slot_q <= '0;
                    row_q  <= row_q + 1'b1;
                end else if (row_q < ROW_W'(NUM_DRV)) begin
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        state_o    = state_q;
        row_o      = row_q;
        sample_b_o = (state_q == KS_SCAN_B);
        sample_o   = tick && scanning && (row_q < ROW_W'(NUM_DRV)) &&
                     (slot_q == SLOT_W'(SLOT_LEN - 1));
        start_o    = ((state_q == KS_IDLE) && tick && sense_any) ||
                     ((state_q == KS_REQ) && read_done);
        eval_o     = tick && (state_q == KS_SETTLE) &&
                     (win_q == WIN_W'(ACCEPT_LEN - 1));
    end

    logic in_req;
    assign in_req = (state_q == KS_REQ);

    // R2: a request is entered only on the last tick of a full window
    assert_req_after_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_req) |-> ($past(win_q) == WIN_W'(ACCEPT_LEN - 1)));
endmodule

// File: rtl/kscan_drive.sv
module kscan_drive
    import kscan_pkg::*;
#(
    parameter int NUM_DRV   = 6,
    localparam int ROW_W    = $clog2(NUM_DRV + 1)
) (
    input  logic               rst_n,
    input  kscan_state_e       state,
    input  logic [ROW_W-1:0]   row,
    input  logic [1:0]         sleep_code,
    input  logic [1:0]         row_sel,
    output logic [NUM_DRV-1:0] drive,
    output logic [NUM_DRV-1:0] row_en,
    output logic               asleep
);
    localparam logic [NUM_DRV-1:0] RST_PAT = {1'b1, {(NUM_DRV-1){1'b0}}};

    logic [NUM_DRV-1:0] idle_hi, scan_hot;
    logic               scanning;

    for (genvar r = 0; r < NUM_DRV; r++) begin : g_line
        localparam bit IS_TOP  = (r == NUM_DRV - 1);
        localparam bit IS_NEXT = (r == NUM_DRV - 2);
        assign idle_hi[r]  = (sleep_code == 2'b00) || (sleep_code == 2'b11) ||
                             IS_TOP || ((sleep_code == 2'b10) && IS_NEXT);
        assign scan_hot[r] = (row == ROW_W'(r));
        if (r == 0) begin : g_first
            assign row_en[r] = (row_sel == 2'b00);
        end else if (r == 1) begin : g_second
            assign row_en[r] = !row_sel[1];
        end else begin : g_fixed
            assign row_en[r] = 1'b1;
        end
    end

    assign scanning = (state == KS_SCAN_A) || (state == KS_SCAN_B);
    assign asleep   = |sleep_code;

    always_comb begin
        if (!rst_n)        drive = RST_PAT;
        else if (scanning) drive = scan_hot & row_en;
        else               drive = idle_hi & row_en;
    end
endmodule

// File: rtl/kscan_capture.sv
module kscan_capture #(
    parameter int NUM_DRV  = 6,
    parameter int NUM_SNS  = 5,
    localparam int KEYS    = NUM_DRV * NUM_SNS,
    localparam int ROW_W   = $clog2(NUM_DRV + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SNS-1:0] sense,
    input  logic [ROW_W-1:0]   row,
    input  logic               sample,
    input  logic               sample_b,
    input  logic               start,
    input  logic               eval,
    input  logic               asleep,
    input  logic [NUM_DRV-1:0] row_en,
    output logic               match,
    output logic               image_zero,
    output logic [KEYS-1:0]    key_data,
    output logic               sleep_ack
);
    logic [KEYS-1:0] img_a, img_b;
    logic            ack_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            img_a     <= '0;
            img_b     <= '0;
            ack_pend  <= 1'b0;
            key_data  <= '0;
            sleep_ack <= 1'b0;
        end else begin
            if (start) ack_pend <= asleep;
            for (int r = 0; r < NUM_DRV; r++) begin
                if (sample && row == ROW_W'(r)) begin
                    if (sample_b) img_b[r*NUM_SNS +: NUM_SNS] <= sense & {NUM_SNS{row_en[r]}};
                    else          img_a[r*NUM_SNS +: NUM_SNS] <= sense & {NUM_SNS{row_en[r]}};
                end
            end
            if (eval && match) begin
                key_data  <= img_b;
                sleep_ack <= ack_pend;
            end
        end
    end

    assign match      = (img_a == img_b);
    assign image_zero = (img_b == '0);

    // R3: a disagreeing window leaves the published image untouched
    assert_hold_on_mismatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !match) |=> $stable(key_data));
    // R2: the published image moves only at an agreed decision
    assert_update_only_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(eval && match) |=> $stable(key_data) && $stable(sleep_ack));
endmodule

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner
    import kscan_pkg::*;
#(
    parameter int NUM_DRV    = 6,
    parameter int NUM_SNS    = 5,
    parameter int SCAN_LEN   = 375,
    parameter int ACCEPT_LEN = 800,
    localparam int KEYS      = NUM_DRV * NUM_SNS,
    localparam int ROW_W     = $clog2(NUM_DRV + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_tick,
    input  logic [NUM_SNS-1:0] sense,
    input  logic [1:0]         sleep_code,
    input  logic [1:0]         row_sel,
    input  logic               xfer_active,
    input  logic               read_done,
    output logic [NUM_DRV-1:0] drive,
    output logic [KEYS-1:0]    key_data,
    output logic               sleep_ack,
    output logic               req_n,
    output logic               osc_wake
);
    kscan_state_e       state;
    logic [ROW_W-1:0]   row;
    logic               sample, sample_b, start, eval, match, image_zero, asleep;
    logic [NUM_DRV-1:0] row_en;

    kscan_fsm #(.NUM_DRV(NUM_DRV), .SCAN_LEN(SCAN_LEN), .ACCEPT_LEN(ACCEPT_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(osc_tick), .sense_any(|sense),
        .read_done(read_done), .match(match), .image_zero(image_zero),
        .state_o(state), .row_o(row), .sample_o(sample), .sample_b_o(sample_b),
        .start_o(start), .eval_o(eval)
    );

    kscan_drive #(.NUM_DRV(NUM_DRV)) u_drive (
        .rst_n(rst_n), .state(state), .row(row), .sleep_code(sleep_code),
        .row_sel(row_sel), .drive(drive), .row_en(row_en), .asleep(asleep)
    );

    kscan_capture #(.NUM_DRV(NUM_DRV), .NUM_SNS(NUM_SNS)) u_capture (
        .clk(clk), .rst_n(rst_n), .sense(sense), .row(row), .sample(sample),
        .sample_b(sample_b), .start(start), .eval(eval), .asleep(asleep),
        .row_en(row_en), .match(match), .image_zero(image_zero),
        .key_data(key_data), .sleep_ack(sleep_ack)
    );

    assign req_n    = (state != KS_REQ) || xfer_active;
    assign osc_wake = !asleep || (state != KS_IDLE) || (|sense);

    // R4: at most one drive line is raised while a pass runs
    assert_single_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == KS_SCAN_A) || (state == KS_SCAN_B)) |-> $onehot0(drive));
    // R9: sleep code 01 parks only the top line high while idle
    assert_sleep_top_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == KS_IDLE) && (sleep_code == 2'b01)) |->
        (drive == {1'b1, {(NUM_DRV-1){1'b0}}}));
endmodule

// File: tb/tb_key_matrix_scanner.sv
`timescale 1ns/1ps
module tb_key_matrix_scanner;
    logic        clk = 1'b0;
    logic        rst_n, osc_tick, xfer_active, read_done;
    logic [4:0]  sense;
    logic [1:0]  sleep_code, row_sel;
    logic [5:0]  drive;
    logic [29:0] key_data;
    logic        sleep_ack, req_n, osc_wake;
    logic [29:0] pressed;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct packed {
        logic [29:0] keys;
        logic        ack;
        int          start;
        int          lat;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    key_matrix_scanner dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sense(sense),
        .sleep_code(sleep_code), .row_sel(row_sel), .xfer_active(xfer_active),
        .read_done(read_done), .drive(drive), .key_data(key_data),
        .sleep_ack(sleep_ack), .req_n(req_n), .osc_wake(osc_wake)
    );

    // physical matrix: a pressed key joins its drive line to its sense line
    always_comb begin
        for (int c = 0; c < 5; c++) begin
            logic s;
            s = 1'b0;
            for (int r = 0; r < 6; r++) s = s | (drive[r] & pressed[r*5+c]);
            sense[c] = s;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side of the scoreboard: the window opens on the next edge
    task automatic expect_req(input logic [29:0] keys, input logic ack, input int lat);
        exp_t e;
        e.keys = keys; e.ack = ack; e.start = cyc + 1; e.lat = lat;
        q.push_back(e);
    endtask

    task automatic pulse_read(input bit held, input logic [29:0] keys, input logic ack);
        read_done = 1'b1;
        if (held) expect_req(keys, ack, 800);
        @(negedge clk);
        read_done = 1'b0;
    endtask

    // monitor side: every falling request is matched against the queue
    logic prev_req = 1'b1;
    logic prev_xfer = 1'b0;
    always begin
        @(negedge clk);
        #1;
        if (!rst_n) begin
            prev_req = 1'b1;
            prev_xfer = 1'b0;
        end else begin
            if (prev_req && !req_n && !prev_xfer) begin
                if (q.size() == 0) begin
                    chk("R3 unexpected request", 64'(req_n), 64'(1));
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R2/R3 request latency", 64'(cyc - e.start), 64'(e.lat));
                    chk("R1 key image", 64'(key_data), 64'(e.keys));
                    chk("R10 sleep ack", 64'(sleep_ack), 64'(e.ack));
                end
            end
            prev_req = req_n;
            prev_xfer = xfer_active;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; osc_tick = 1'b1; xfer_active = 1'b0; read_done = 1'b0;
        sleep_code = 2'b00; row_sel = 2'b00; pressed = '0;
        wait_cyc(3);
        chk("R12 reset drive", 64'(drive), 64'(6'b100000));
        chk("R12 reset req", 64'(req_n), 64'(1));
        chk("R12 reset data", 64'(key_data), 64'(0));
        chk("R12 reset ack", 64'(sleep_ack), 64'(0));
        rst_n = 1'b1;
        wait_cyc(2);
        chk("R4 normal idle drive", 64'(drive), 64'(6'h3F));
        chk("R11 wake in normal mode", 64'(osc_wake), 64'(1));

        // single key, line 1 sense 1; scan order checked in mid-pass
        pressed = 30'h1;
        expect_req(30'h1, 1'b0, 800);
        wait_cyc(10);
        chk("R4 slot of line 1", 64'(drive), 64'(6'b000001));
        wait_cyc(60);
        chk("R4 slot of line 2", 64'(drive), 64'(6'b000010));
        wait_cyc(735);
        chk("R1 key bit 0", 64'(key_data), 64'(1));
        chk("R2 request low", 64'(req_n), 64'(0));

        // read while still held: request clears, returns after a window
        pulse_read(1'b1, 30'h1, 1'b0);
        chk("R6 request cleared by read", 64'(req_n), 64'(1));
        wait_cyc(805);
        chk("R6 request back while held", 64'(req_n), 64'(0));

        // host transfer masks the request without losing it
        xfer_active = 1'b1;
        #0.5;
        chk("R7 request masked in transfer", 64'(req_n), 64'(1));
        @(negedge clk);
        xfer_active = 1'b0;
        #0.5;
        chk("R7 request returns after transfer", 64'(req_n), 64'(0));
        @(negedge clk);

        // release and read: empty image, back to idle
        pressed = '0;
        pulse_read(1'b0, '0, 1'b0);
        wait_cyc(810);
        chk("R5 data cleared on release", 64'(key_data), 64'(0));
        chk("R5 no request on release", 64'(req_n), 64'(1));
        chk("R4 idle again", 64'(drive), 64'(6'h3F));

        // read pulse outside a request is ignored
        pulse_read(1'b0, '0, 1'b0);
        wait_cyc(5);
        chk("R6 stray read ignored", 64'(req_n), 64'(1));
        chk("R6 stray read keeps data", 64'(key_data), 64'(0));

        // several keys at once
        pressed = (30'h1 << 7) | (30'h1 << 29);
        expect_req((30'h1 << 7) | (30'h1 << 29), 1'b0, 800);
        wait_cyc(805);
        chk("R5 two bits reported", 64'(key_data), 64'((30'h1 << 7) | (30'h1 << 29)));
        pressed = '0;
        pulse_read(1'b0, '0, 1'b0);
        wait_cyc(810);

        // bounce: second key appears between the two samples of line 5
        pressed = 30'h1 << 12;
        expect_req((30'h1 << 12) | (30'h1 << 20), 1'b0, 1600);
        wait_cyc(400);
        pressed = (30'h1 << 12) | (30'h1 << 20);
        wait_cyc(405);
        chk("R3 no request after first window", 64'(req_n), 64'(1));
        chk("R3 data kept on mismatch", 64'(key_data), 64'(0));
        wait_cyc(800);
        chk("R3 request after retry", 64'(req_n), 64'(0));
        pressed = '0;
        pulse_read(1'b0, '0, 1'b0);
        wait_cyc(810);

        // short press is never reported
        pressed = 30'h1 << 3;
        wait_cyc(300);
        pressed = '0;
        wait_cyc(1700);
        chk("R3 short press not reported", 64'(req_n), 64'(1));
        chk("R3 short press leaves data", 64'(key_data), 64'(0));

        // row selection: line 1 removed
        row_sel = 2'b01;
        wait_cyc(2);
        chk("R8 line 1 removed idle", 64'(drive), 64'(6'b111110));
        pressed = 30'h1 | (30'h1 << 6);
        expect_req(30'h1 << 6, 1'b0, 800);
        wait_cyc(805);
        chk("R8 removed row bit reads 0", 64'(key_data), 64'(30'h1 << 6));
        row_sel = 2'b10;
        wait_cyc(1);
        chk("R8 lines 1 and 2 removed", 64'(drive), 64'(6'b111100));
        pressed = '0;
        pulse_read(1'b0, '0, 1'b0);
        wait_cyc(810);
        pressed = 30'h1 << 5;
        wait_cyc(900);
        chk("R8 removed line cannot start", 64'(req_n), 64'(1));
        pressed = '0;
        row_sel = 2'b00;
        wait_cyc(2);

        // sleep idle patterns and wake
        sleep_code = 2'b01;
        wait_cyc(2);
        chk("R9 code 01 pattern", 64'(drive), 64'(6'b100000));
        chk("R11 asleep no wake", 64'(osc_wake), 64'(0));
        sleep_code = 2'b10;
        wait_cyc(2);
        chk("R9 code 10 pattern", 64'(drive), 64'(6'b110000));
        sleep_code = 2'b11;
        wait_cyc(2);
        chk("R9 code 11 pattern", 64'(drive), 64'(6'b111111));
        chk("R11 asleep all high no wake", 64'(osc_wake), 64'(0));
        sleep_code = 2'b01;
        pressed = 30'h1;
        wait_cyc(2);
        chk("R11 low line press no wake", 64'(osc_wake), 64'(0));
        wait_cyc(900);
        chk("R9 low line press no request", 64'(req_n), 64'(1));
        pressed = 30'h1 << 25;
        expect_req(30'h1 << 25, 1'b1, 800);
        #1;
        chk("R11 wake on raised line press", 64'(osc_wake), 64'(1));
        wait_cyc(805);
        chk("R10 ack set for sleep press", 64'(sleep_ack), 64'(1));
        pressed = '0;
        pulse_read(1'b0, '0, 1'b0);
        wait_cyc(810);
        sleep_code = 2'b00;
        wait_cyc(2);

        // reset during an active request
        pressed = 30'h1 << 1;
        expect_req(30'h1 << 1, 1'b0, 800);
        wait_cyc(805);
        rst_n = 1'b0;
        #1;
        chk("R12 reset clears data", 64'(key_data), 64'(0));
        chk("R12 reset raises request", 64'(req_n), 64'(1));
        chk("R12 reset drive pattern", 64'(drive), 64'(6'b100000));
        wait_cyc(3);
        pressed = '0;
        rst_n = 1'b1;
        wait_cyc(5);

        chk("R2 all expected requests seen", 64'(q.size()), 64'(0));
        summary();
        $finish;
    end
endmodule